// File: doc/BRIEF.md
# Down-Counting Reload Timer

This block is a down counter of parameterised width. It is set up through a small register bus with a write strobe, an address and write data, and its registers read back on a combinational read port. Software loads a reload value and then writes the control register. To start a count, it sets the run bit and the start bit in the same write. The counter loads the reload value and then decrements by one on each cycle in which the count-tick input is high.

Decrementing from zero is an underflow. In one-shot mode the counter stops at that point. In auto-reload mode it reloads and keeps running. Each underflow sets a sticky flag. The flag drives an interrupt request when interrupts are enabled.

The timer also produces a waveform. In one-shot mode it is a pulse that lasts as long as the count, with a polarity chosen by a level bit. In auto-reload mode it toggles at every underflow. A pin-select bit puts either this waveform or a general-purpose value on the output pin.

Top module: `rtimer_top`

## Requirements
- R1: After reset the control register (address 0) reads 0, the count (address 2) and reload (address 1) read 0, `irq` is low and `pin_out` follows `gpio_val`.
- R2: A control write with bit 6 (start) = 1 and bit 0 (run) = 1 loads the count from the reload register at that clock edge, and counting begins. Bit 6 always reads back as 0.
- R3: A start write whose bit 0 is 0 does not load or start the counter. A control write with bit 6 = 0 does not restart a running count.
- R4: While running, the count drops by exactly one on each clock with `cnt_tick` = 1 and holds on clocks with `cnt_tick` = 0.
- R5: One-shot mode (control bit 1 = 0): a tick at count 0 stops the counter, and the count then holds at 0.
- R6: Auto-reload mode (control bit 1 = 1): a tick at count 0 loads the reload value and counting continues.
- R7: The underflow flag (control bit 5) becomes 1 at the edge of the underflow tick. A control write with bit 5 = 0 clears it, and a write with bit 5 = 1 leaves it unchanged.
- R8: `irq` is high exactly when the flag is 1 and control bit 4 (interrupt enable) is 1.
- R9: In one-shot mode the timer output is the inverse of control bit 2 (level) from the start edge until the underflow edge, and equals bit 2 after it.
- R10: In auto-reload mode the timer output equals control bit 2 at the start edge and inverts at every underflow.
- R11: `pin_out` carries the timer output when control bit 3 is 1, and `gpio_val` when it is 0.
- R12: A control write with bit 0 = 0 stops the counter at that edge. The count and the timer output hold their values, and later ticks change neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 reload, 2 count (read only) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| cnt_tick | input | 1 | Count-clock enable: one decrement per high cycle |
| gpio_val | input | 1 | General-purpose value routed to the pin when the timer output is not selected |
| pin_out | output | 1 | Pin level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `cnt_tick`, `bus_we` and the bus fields are stable around each rising edge. They also assume that the first bus cycle comes only after the internal synchronised reset has been released, so that no write or tick is lost during release. The stimulus drives every input a fixed delay after the falling edge. It holds off all writes and ticks for several cycles after `rst_n` rises. The only start writes it issues carry run = 1, except the one deliberate start with run = 0 that exercises R3.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // control register bit positions (software-visible layout)
  localparam int unsigned B_RUN  = 0;
  localparam int unsigned B_AUTO = 1;
  localparam int unsigned B_LVL  = 2;
  localparam int unsigned B_PSEL = 3;
  localparam int unsigned B_IE   = 4;
  localparam int unsigned B_FLAG = 5;
  localparam int unsigned B_GO   = 6;
  localparam int unsigned CTRL_W = 7;

  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd2;

  typedef struct packed {
    logic irq_en;
    logic pin_sel;
    logic lvl;
    logic auto_rl;
    logic run;
  } tmr_cfg_t;

endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              uf,
  output tmr_cfg_t          cfg_q,
  output tmr_cfg_t          cfg_nx,
  output logic [CNT_W-1:0]  reload_q,
  output logic              flag_q,
  output logic              trig,
  output logic              stop
);

  logic             wctrl;
  logic             wrel;
  logic             flag_nx;
  logic [CNT_W-1:0] reload_nx;

  always_comb begin
    wctrl  = wr_en && (addr == A_CTRL);
    wrel   = wr_en && (addr == A_RELOAD);
    cfg_nx = cfg_q;
    if (wctrl) begin
      cfg_nx.irq_en  = wdata[B_IE];
      cfg_nx.pin_sel = wdata[B_PSEL];
      cfg_nx.lvl     = wdata[B_LVL];
      cfg_nx.auto_rl = wdata[B_AUTO];
      cfg_nx.run     = wdata[B_RUN];
    end
    trig = wctrl && wdata[B_GO] && wdata[B_RUN];
    stop = wctrl && !wdata[B_RUN];
    flag_nx = flag_q;
    if (uf) begin
      flag_nx = 1'b1;
    end else if (wctrl && !wdata[B_FLAG]) begin
      flag_nx = 1'b0;
    end
    reload_nx = wrel ? wdata : reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      flag_q   <= 1'b0;
      reload_q <= '0;
    end else begin
      cfg_q    <= cfg_nx;
      flag_q   <= flag_nx;
      reload_q <= reload_nx;
    end
  end

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> flag_q)
    else $error("underflow did not set flag");

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL && !wdata[B_FLAG] && !uf) |=> !flag_q)
    else $error("flag not cleared by write of 0");

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             stop,
  input  logic             tick,
  input  logic             auto_rl,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active_q,
  output logic             uf
);

  logic [CNT_W-1:0] cnt_nx;
  logic             active_nx;
  logic             at_zero;

  always_comb begin
    at_zero   = (cnt_q == '0);
    uf        = active_q && tick && at_zero && !trig && !stop;
    cnt_nx    = cnt_q;
    active_nx = active_q;
    if (trig) begin
      cnt_nx    = reload;
      active_nx = 1'b1;
    end else if (stop) begin
      active_nx = 1'b0;
    end else if (active_q && tick) begin
      if (at_zero) begin
        if (auto_rl) begin
          cnt_nx = reload;
        end else begin
          active_nx = 1'b0;
        end
      end else begin
        cnt_nx = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nx;
      active_q <= active_nx;
    end
  end

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && tick && cnt_q != '0 && !trig && !stop) |=> (cnt_q == $past(cnt_q) - 1'b1))
    else $error("count did not drop by one");

  assert_oneshot_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !auto_rl) |=> (!active_q && cnt_q == '0))
    else $error("one-shot kept running");

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && auto_rl) |=> (active_q && cnt_q == $past(reload)))
    else $error("reload missed");

  assert_stop_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!active_q && cnt_q == $past(cnt_q)))
    else $error("stop did not hold count");

endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic uf,
  input  logic auto_q,
  input  logic lvl_q,
  input  logic auto_nx,
  input  logic lvl_nx,
  input  logic pin_sel,
  input  logic gpio_val,
  output logic pin_out
);

  logic tout_q;
  logic tout_nx;

  always_comb begin
    tout_nx = tout_q;
    if (trig) begin
      tout_nx = auto_nx ? lvl_nx : !lvl_nx;
    end else if (uf) begin
      tout_nx = auto_q ? !tout_q : lvl_q;
    end
    pin_out = pin_sel ? tout_q : gpio_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_q <= 1'b0;
    end else begin
      tout_q <= tout_nx;
    end
  end

  assert_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && auto_q) |=> (tout_q != $past(tout_q)))
    else $error("no toggle at underflow");

  assert_oneshot_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !auto_q) |=> (tout_q == $past(lvl_q)))
    else $error("one-shot output not back at idle level");

endmodule

// File: rtl/rtimer_top.sv
module rtimer_top
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cnt_tick,
  input  logic              gpio_val,
  output logic              pin_out,
  output logic              irq
);

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  tmr_cfg_t         cfg_q;
  tmr_cfg_t         cfg_nx;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             trig;
  logic             stop;
  logic             uf;
  logic             active_q;
  logic [CTRL_W-1:0] ctrl_vec;

  tmr_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .uf       (uf),
    .cfg_q    (cfg_q),
    .cfg_nx   (cfg_nx),
    .reload_q (reload_q),
    .flag_q   (flag_q),
    .trig     (trig),
    .stop     (stop)
  );

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig     (trig),
    .stop     (stop),
    .tick     (cnt_tick),
    .auto_rl  (cfg_q.auto_rl),
    .reload   (reload_q),
    .cnt_q    (cnt_q),
    .active_q (active_q),
    .uf       (uf)
  );

  tmr_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig     (trig),
    .uf       (uf),
    .auto_q   (cfg_q.auto_rl),
    .lvl_q    (cfg_q.lvl),
    .auto_nx  (cfg_nx.auto_rl),
    .lvl_nx   (cfg_nx.lvl),
    .pin_sel  (cfg_q.pin_sel),
    .gpio_val (gpio_val),
    .pin_out  (pin_out)
  );

  always_comb begin
    ctrl_vec         = '0;
    ctrl_vec[B_RUN]  = cfg_q.run;
    ctrl_vec[B_AUTO] = cfg_q.auto_rl;
    ctrl_vec[B_LVL]  = cfg_q.lvl;
    ctrl_vec[B_PSEL] = cfg_q.pin_sel;
    ctrl_vec[B_IE]   = cfg_q.irq_en;
    ctrl_vec[B_FLAG] = flag_q;
    case (bus_addr)
      A_CTRL:   bus_rdata = CNT_W'(ctrl_vec);
      A_RELOAD: bus_rdata = reload_q;
      A_COUNT:  bus_rdata = cnt_q;
      default:  bus_rdata = '0;
    endcase
    irq = flag_q && cfg_q.irq_en;
  end

  assert_active_needs_run_R12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    active_q |-> cfg_q.run)
    else $error("counter active with run bit clear");

  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq) |-> (flag_q && cfg_q.irq_en))
    else $error("irq raised without flag and enable");

endmodule

// File: tb/rtimer_top_test.sv
module rtimer_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        cnt_tick;
  logic        gpio_val;
  logic        pin_out;
  logic        irq;

  int checks;
  int errors;
  bit cmp_on;

  rtimer_top uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
    .gpio_val(gpio_val), .pin_out(pin_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference state
  logic [15:0] m_cnt, m_rel;
  bit m_act, m_tout, m_flag, m_run, m_auto, m_lvl, m_psel, m_ie;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_act = 0; m_tout = 0; m_flag = 0;
      m_run = 0; m_auto = 0; m_lvl = 0; m_psel = 0; m_ie = 0;
    end else begin
      bit wc, go, halt, under;
      wc    = bus_we && bus_addr == 2'd0;
      go    = wc && bus_wdata[6] && bus_wdata[0];
      halt  = wc && !bus_wdata[0];
      under = m_act && cnt_tick && m_cnt == 0 && !go && !halt;
      if (go) begin
        m_cnt = m_rel; m_act = 1;
        m_tout = bus_wdata[1] ? bus_wdata[2] : !bus_wdata[2];
      end else if (halt) begin
        m_act = 0;
      end else if (m_act && cnt_tick) begin
        if (m_cnt == 0) begin
          if (m_auto) begin m_cnt = m_rel; m_tout = !m_tout; end
          else begin m_act = 0; m_tout = m_lvl; end
        end else m_cnt = m_cnt - 1;
      end
      if (under) m_flag = 1;
      else if (wc && !bus_wdata[5]) m_flag = 0;
      if (wc) begin
        m_run = bus_wdata[0]; m_auto = bus_wdata[1]; m_lvl = bus_wdata[2];
        m_psel = bus_wdata[3]; m_ie = bus_wdata[4];
      end
      if (bus_we && bus_addr == 2'd1) m_rel = bus_wdata;
    end
  end

  function automatic logic [15:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {10'd0, m_flag, m_ie, m_psel, m_lvl, m_auto, m_run};
      2'd1: return m_rel;
      2'd2: return m_cnt;
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 irq model", {15'd0, irq}, {15'd0, m_flag && m_ie});
      chk("R11 pin model", {15'd0, pin_out}, {15'd0, m_psel ? m_tout : gpio_val});
      chk("R2 rdata model", bus_rdata, m_read(bus_addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic ticks(input int n);
    cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    #1 cnt_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    checks = 0; errors = 0; cmp_on = 0;
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; cnt_tick = 0; gpio_val = 1;
    idle(3);
    rst_n = 1;
    idle(4);
    cmp_on = 1;

    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl", v, 16'h0);
    peek(2'd2, v); chk("R1 count", v, 16'h0);
    peek(2'd1, v); chk("R1 reload", v, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    chk("R1 pin", {15'd0, pin_out}, 16'd1);

    // R3 start with run=0 ignored
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0040);
    peek(2'd2, v); chk("R3 count", v, 16'h0);
    peek(2'd0, v); chk("R3 ctrl", v, 16'h0);

    // R2/R9 one-shot start: run, pin_sel, irq_en, start, lvl=0
    wr(2'd0, 16'h0059);
    peek(2'd2, v); chk("R2 load", v, 16'd5);
    peek(2'd0, v); chk("R2 start reads 0", v, 16'h0019);
    chk("R9 pulse level", {15'd0, pin_out}, 16'd1);
    ticks(5);
    peek(2'd2, v); chk("R4 count", v, 16'd0);
    chk("R9 still counting", {15'd0, pin_out}, 16'd1);
    ticks(1);
    peek(2'd0, v); chk("R7 flag set", v, 16'h0039);
    chk("R8 irq", {15'd0, irq}, 16'd1);
    chk("R9 idle level", {15'd0, pin_out}, 16'd0);
    ticks(3);
    peek(2'd2, v); chk("R5 holds", v, 16'd0);
    chk("R5 pin", {15'd0, pin_out}, 16'd0);

    // R7 write 1 keeps flag, write 0 clears
    wr(2'd0, 16'h0039);
    peek(2'd0, v); chk("R7 write1", v, 16'h0039);
    peek(2'd2, v); chk("R3 no restart", v, 16'd0);
    wr(2'd0, 16'h0019);
    peek(2'd0, v); chk("R7 write0", v, 16'h0019);
    chk("R8 irq low", {15'd0, irq}, 16'd0);

    // R6/R10 auto-reload with lvl=1
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h004F);
    chk("R10 start level", {15'd0, pin_out}, 16'd1);
    ticks(3);
    peek(2'd2, v); chk("R6 reloaded", v, 16'd2);
    chk("R10 toggle1", {15'd0, pin_out}, 16'd0);
    peek(2'd0, v); chk("R7 flag auto", v, 16'h002F);
    ticks(3);
    chk("R10 toggle2", {15'd0, pin_out}, 16'd1);
    peek(2'd2, v); chk("R6 reloaded2", v, 16'd2);

    // R4 tick gating
    ticks(1);
    idle(3);
    peek(2'd2, v); chk("R4 hold no tick", v, 16'd1);

    // alternate tick pattern
    for (int i = 0; i < 6; i++) begin
      cnt_tick = i[0];
      idle(1);
    end
    cnt_tick = 0;

    // R12 stop holds count and output
    peek(2'd2, v);
    begin
      logic [15:0] held; logic hp;
      held = v; hp = pin_out;
      wr(2'd0, 16'h000E);
      ticks(4);
      peek(2'd2, v); chk("R12 count held", v, held);
      chk("R12 pin held", {15'd0, pin_out}, {15'd0, hp});
    end
    chk("R8 ie off", {15'd0, irq}, 16'd0);

    // R11 pin mux
    wr(2'd0, 16'h0006);
    gpio_val = 0; #1;
    chk("R11 gpio0", {15'd0, pin_out}, 16'd0);
    gpio_val = 1; #1;
    chk("R11 gpio1", {15'd0, pin_out}, 16'd1);
    idle(2);

    cmp_on = 0;
    finish_run();
  end
endmodule